// File: doc/BRIEF.md
# Multiplexed Host Bus to Wishbone Bridge

This block is a synchronous slave on a processor's external-memory bus. The bus carries address and data on the same 16 lines, one after the other. The bridge runs on the bus clock that the host supplies and acts as a 16-bit Wishbone master towards the fabric. It supports only single full-word accesses under one active-low chip select. Every access is turned into exactly one Wishbone read or write cycle, and read data goes back onto the shared lines within the host's fixed wait-state window.

An access starts with a one-cycle, active-low address strobe. In that cycle the bridge latches the address from the shared lines. Chip select then falls and stays low for `WAIT_STATES` cycles (four by default). The direction line is low for a read. For a write it rises together with chip select, and the write data sits on the shared lines. The bridge decides between read and write at the first data-phase edge and starts the Wishbone cycle right after that edge.

A read whose acknowledge comes too late leaves a fixed filler word on the bus. A cycle that is still pending when chip select is released is abandoned, so the host can never hang the bridge. The shared lines are presented as separate input, output and output-enable ports. The bidirectional pad sits outside this block.

Top module: `mhb_bridge`

## Requirements
- R1: A synchronous active-high reset, including one asserted in the middle of an access, leaves wb_cyc_o, wb_stb_o and bus_ad_oe low from the next clock on.
- R2: At a rising edge where the bridge is idle and bus_adv_n is low, bus_ad_i is latched as the address. It appears on wb_adr_o for the whole Wishbone cycle of that access.
- R3: For a read (bus_dir low at the first edge with bus_cs_n low), wb_cyc_o and wb_stb_o rise after that edge with wb_we_o low. They stay high until wb_ack_i is sampled or chip select is released.
- R4: If the read acknowledge is sampled within the first WAIT_STATES-2 edges after the Wishbone cycle starts (ack latency 0 or 1 cycle with four wait states), bus_ad_o carries wb_dat_i in the last wait-state cycle.
- R5: If the read acknowledge is sampled later, or never, bus_ad_o carries the filler word FILL (0x0000 by default) in the last wait-state cycle.
- R6: A Wishbone cycle with no acknowledge at the edge where bus_cs_n is sampled high is dropped. wb_cyc_o is low after that edge.
- R7: For a write (bus_dir high at the first edge with bus_cs_n low), bus_ad_i is captured at that edge. A cycle with wb_we_o high then carries the latched address and the captured word on wb_dat_o.
- R8: bus_ad_oe is high only during the data phase of a read while bus_cs_n is low and bus_dir is low. It stays low when idle and throughout writes.
- R9: While a Wishbone cycle waits for wb_ack_i with chip select low, wb_adr_o, wb_we_o and wb_dat_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock from the host; all signals sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_adv_n | input | 1 | Address-valid strobe, active low, one cycle per access |
| bus_cs_n | input | 1 | Chip select, active low, held for the data phase |
| bus_dir | input | 1 | Direction: 1 = write, 0 = read |
| bus_ad_i | input | 16 | Value seen on the shared address/data lines |
| bus_ad_o | output | 16 | Read data to drive onto the shared lines |
| bus_ad_oe | output | 1 | Enables the pad driver for bus_ad_o |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | 16 | Wishbone word address |
| wb_dat_o | output | 16 | Wishbone write data |
| wb_dat_i | input | 16 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
The assertions assume a well-formed host. The address strobe is asserted only while the bridge is idle. The direction line changes only together with chip select. The Wishbone slave raises acknowledge only while the cycle is active. The bench meets these assumptions by driving every access from one task that follows the strobe, chip-select and direction sequence exactly. A slave model acknowledges only while it sees wb_cyc_o high, after a programmed latency. The latencies are chosen on both sides of the read deadline and beyond chip-select release.

// File: rtl/mhb_pkg.sv
package mhb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,   // waiting for an address strobe
    ST_ADDR,   // address held, direction not yet known
    ST_BUS,    // Wishbone cycle in flight
    ST_TAIL    // cycle finished, waiting for chip select release
  } mhb_state_e;

  // edges_done: data-phase edges already counted before this edge (edge k holds k-1).
  // Read data must be registered no later than edge ws-1 to be on the lines at edge ws.
  function automatic logic ack_in_window(input int unsigned edges_done, input int unsigned ws);
    return (edges_done + 1) < ws;
  endfunction

endpackage

// File: rtl/mhb_seq.sv
module mhb_seq
  import mhb_pkg::*;
#(
  parameter int WS = 4,
  localparam int CW = $clog2(WS + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_n,
  input  logic cs_n,
  input  logic ack,
  output logic cyc,
  output logic ev_addr,
  output logic ev_start,
  output logic rd_ok,
  output logic data_phase
);

  localparam logic [CW-1:0] CMAX = CW'(WS + 1);

  mhb_state_e    st;
  logic [CW-1:0] cnt;
  logic          ev_ack;
  logic          ev_drop;

  assign ev_addr    = (st == ST_IDLE) && !adv_n;
  assign ev_start   = (st == ST_ADDR) && !cs_n;
  assign cyc        = (st == ST_BUS);
  assign ev_ack     = cyc && ack;
  assign ev_drop    = cyc && !ack && cs_n;
  assign rd_ok      = ev_ack && ack_in_window(32'(cnt), 32'(WS));
  assign data_phase = (st == ST_BUS) || (st == ST_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      if (data_phase && !cs_n && cnt < CMAX) cnt <= cnt + 1'b1;
      case (st)
        ST_IDLE: if (ev_addr) st <= ST_ADDR;
        ST_ADDR: begin
          if (!cs_n) begin
            st  <= ST_BUS;
            cnt <= CW'(1);
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_BUS: begin
          if (ev_ack)       st <= cs_n ? ST_IDLE : ST_TAIL;
          else if (ev_drop) st <= ST_IDLE;
        end
        ST_TAIL: if (cs_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (rst)
    cyc && !ack && !cs_n |=> cyc); // R3

  AST_DROP_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cyc && !ack && cs_n |=> !cyc); // R6

endmodule

// File: rtl/mhb_wbm.sv
module mhb_wbm #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_addr,
  input  logic          ev_start,
  input  logic          cyc,
  input  logic          ack,
  input  logic          cs_n,
  input  logic          dir,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] adr_q,
  output logic          we_q,
  output logic [DW-1:0] dat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_q <= '0;
      we_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      if (ev_addr) adr_q <= ad_i;
      if (ev_start) begin
        we_q <= dir;
        if (dir) dat_q <= ad_i;
      end
    end
  end

  AST_ADDR_LATCH: assert property (@(posedge clk) disable iff (rst)
    ev_addr |=> adr_q == $past(ad_i)); // R2

  AST_WE_FROM_DIR: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc) |-> we_q == $past(dir)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    cyc && !ack && !cs_n |=> $stable(adr_q) && $stable(we_q) && $stable(dat_q)); // R9

endmodule

// File: rtl/mhb_rdret.sv
module mhb_rdret #(
  parameter int          DW   = 16,
  parameter logic [DW-1:0] FILL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_addr,
  input  logic          rd_ok,
  input  logic          we_q,
  input  logic          data_phase,
  input  logic          cs_n,
  input  logic          dir,
  input  logic [DW-1:0] rdat,
  output logic [DW-1:0] ad_o,
  output logic          oe
);

  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst)                 rd_q <= FILL;
    else if (ev_addr)        rd_q <= FILL;
    else if (rd_ok && !we_q) rd_q <= rdat;
  end

  assign ad_o = rd_q;
  assign oe   = data_phase && !we_q && !cs_n && !dir;

  AST_OE_GUARD: assert property (@(posedge clk) disable iff (rst)
    oe |-> !cs_n && !dir && !we_q); // R8

endmodule

// File: rtl/mhb_bridge.sv
module mhb_bridge #(
  parameter int            DW          = 16,
  parameter int            WAIT_STATES = 4,
  parameter logic [DW-1:0] FILL        = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_adv_n,
  input  logic          bus_cs_n,
  input  logic          bus_dir,
  input  logic [DW-1:0] bus_ad_i,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [DW-1:0] wb_adr_o,
  output logic [DW-1:0] wb_dat_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack_i
);

  logic ev_addr, ev_start, rd_ok, data_phase, cyc;

  mhb_seq #(.WS(WAIT_STATES)) u_seq (
    .clk, .rst,
    .adv_n(bus_adv_n), .cs_n(bus_cs_n), .ack(wb_ack_i),
    .cyc, .ev_addr, .ev_start, .rd_ok, .data_phase
  );

  mhb_wbm #(.DW(DW)) u_wbm (
    .clk, .rst, .ev_addr, .ev_start, .cyc,
    .ack(wb_ack_i), .cs_n(bus_cs_n), .dir(bus_dir), .ad_i(bus_ad_i),
    .adr_q(wb_adr_o), .we_q(wb_we_o), .dat_q(wb_dat_o)
  );

  mhb_rdret #(.DW(DW), .FILL(FILL)) u_rdret (
    .clk, .rst, .ev_addr, .rd_ok, .we_q(wb_we_o), .data_phase,
    .cs_n(bus_cs_n), .dir(bus_dir), .rdat(wb_dat_i),
    .ad_o(bus_ad_o), .oe(bus_ad_oe)
  );

  assign wb_cyc_o = cyc;
  assign wb_stb_o = cyc;

endmodule

// File: tb/mhb_bridge_test.sv
`timescale 1ns/1ps
module mhb_bridge_test;

  localparam int WS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_adv_n = 1'b1, bus_cs_n = 1'b1, bus_dir = 1'b0;
  logic [15:0] bus_ad_i = '0;
  logic [15:0] bus_ad_o;
  logic        bus_ad_oe;
  logic        wb_cyc_o, wb_stb_o, wb_we_o;
  logic [15:0] wb_adr_o, wb_dat_o;
  logic [15:0] wb_dat_i = '0;
  logic        wb_ack_i = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  // slave model state
  int          lat = 0, lat_cnt = 0;
  logic [15:0] sl_val = '0;
  bit          acked = 0;
  logic [15:0] seen_adr, seen_dat;
  logic        seen_we, seen_stb;

  mhb_bridge uut (
    .clk, .rst, .bus_adv_n, .bus_cs_n, .bus_dir, .bus_ad_i,
    .bus_ad_o, .bus_ad_oe, .wb_cyc_o, .wb_stb_o, .wb_we_o,
    .wb_adr_o, .wb_dat_o, .wb_dat_i, .wb_ack_i
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  // one negative edge: the slave answers after `lat` cycles of seeing wb_cyc_o
  task automatic step();
    @(negedge clk);
    if (wb_cyc_o) begin
      if (lat_cnt == lat) begin
        wb_ack_i = 1'b1; wb_dat_i = sl_val; acked = 1;
        seen_adr = wb_adr_o; seen_we = wb_we_o; seen_dat = wb_dat_o; seen_stb = wb_stb_o;
      end else begin
        wb_ack_i = 1'b0; lat_cnt++;
      end
    end else begin
      wb_ack_i = 1'b0; lat_cnt = 0;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int l, input logic [15:0] v,
                         input logic [15:0] exp, input bit exp_ack, input string tag);
    logic [15:0] got; logic got_oe;
    lat = l; sl_val = v; acked = 0;
    step(); bus_adv_n = 1'b0; bus_ad_i = a; bus_cs_n = 1'b1; bus_dir = 1'b0;
    step(); bus_adv_n = 1'b1; bus_cs_n = 1'b0; bus_ad_i = '0;
    repeat (WS - 1) step();
    got = bus_ad_o; got_oe = bus_ad_oe;
    step(); bus_cs_n = 1'b1;
    step();
    chk(got_oe == 1'b1, "R8", {tag, " read drive enable"}, 32'(got_oe), 1);
    chk(got == exp, exp == v ? "R4" : "R5", {tag, " read data on bus"}, 32'(got), 32'(exp));
    chk(wb_cyc_o == 1'b0, "R6", {tag, " cycle closed after release"}, 32'(wb_cyc_o), 0);
    chk(bus_ad_oe == 1'b0, "R8", {tag, " idle drive off"}, 32'(bus_ad_oe), 0);
    chk(acked == exp_ack, "R6", {tag, " ack taken"}, 32'(acked), 32'(exp_ack));
    if (exp_ack) begin
      chk(seen_adr == a, "R2", {tag, " address"}, 32'(seen_adr), 32'(a));
      chk(seen_we == 1'b0 && seen_stb == 1'b1, "R3", {tag, " read strobe/we"},
          {seen_stb, seen_we}, 32'b10);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input int l, input logic [15:0] d,
                          input bit exp_ack, input string tag);
    bit oe_seen = 0;
    lat = l; acked = 0;
    step(); bus_adv_n = 1'b0; bus_ad_i = a; bus_cs_n = 1'b1; bus_dir = 1'b0;
    step(); bus_adv_n = 1'b1; bus_cs_n = 1'b0; bus_dir = 1'b1; bus_ad_i = d;
    for (int k = 0; k < WS; k++) begin
      step();
      if (bus_ad_oe) oe_seen = 1;
    end
    bus_cs_n = 1'b1; bus_dir = 1'b0; bus_ad_i = '0;
    step();
    chk(!oe_seen, "R8", {tag, " no drive during write"}, 32'(oe_seen), 0);
    chk(wb_cyc_o == 1'b0, "R6", {tag, " cycle closed after release"}, 32'(wb_cyc_o), 0);
    chk(acked == exp_ack, "R6", {tag, " ack taken"}, 32'(acked), 32'(exp_ack));
    if (exp_ack) begin
      chk(seen_we == 1'b1, "R7", {tag, " write enable"}, 32'(seen_we), 1);
      chk(seen_dat == d, "R7", {tag, " write data"}, 32'(seen_dat), 32'(d));
      chk(seen_adr == a, "R9", {tag, " address held to ack"}, 32'(seen_adr), 32'(a));
    end
  endtask

  task automatic reset_checks();
    chk(wb_cyc_o == 1'b0 && wb_stb_o == 1'b0, "R1", "cyc/stb after reset",
        {wb_cyc_o, wb_stb_o}, 0);
    chk(bus_ad_oe == 1'b0, "R1", "drive after reset", 32'(bus_ad_oe), 0);
  endtask

  task automatic mid_reset();
    lat = 1000; acked = 0;
    step(); bus_adv_n = 1'b0; bus_ad_i = 16'h0ABC;
    step(); bus_adv_n = 1'b1; bus_cs_n = 1'b0; bus_ad_i = '0;
    step(); step();
    chk(wb_cyc_o == 1'b1 && bus_ad_oe == 1'b1, "R3", "read in flight before reset",
        {wb_cyc_o, bus_ad_oe}, 32'b11);
    rst = 1'b1;
    step();
    reset_checks();
    rst = 1'b0; bus_cs_n = 1'b1;
    step(); step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    reset_checks();
    do_read (16'h1234, 0,    16'hCAFE, 16'hCAFE, 1, "lat0");
    do_read (16'h8001, 1,    16'h5A5A, 16'h5A5A, 1, "lat1");
    do_read (16'h00F0, 2,    16'hBEEF, 16'h0000, 1, "late");
    do_read (16'h7777, 1000, 16'h1111, 16'h0000, 0, "noack");
    do_write(16'h4321, 0,    16'hA5C3, 1, "wlat0");
    do_write(16'hFFFE, 2,    16'h0F0F, 1, "wlat2");
    do_write(16'h2222, 1000, 16'h3333, 0, "wnoack");
    do_read (16'hFFFF, 0,    16'hFFFF, 16'hFFFF, 1, "allones");
    mid_reset();
    do_read (16'h0001, 1,    16'h6006, 16'h6006, 1, "after_rst");
    summary();
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule